// File: doc/BRIEF.md
# Pipelined Pre-Adder Multiply-Accumulator

This block is a signed multiply-accumulate datapath. On every enabled clock it adds two operands in a pre-adder and multiplies that sum by a third operand. It then folds the product into a wide running total. The operands pass through a fixed register pipeline: an input capture stage, a pre-adder stage, a product stage and the accumulator. An operand set therefore shows up in the total a fixed number of clocks after it was sampled. The pre-adder sum is one bit wider than its operands. The product is sign-extended to the accumulator width, and the total wraps modulo two to the accumulator width.

Data flows through the block without a handshake. The clock enable is the only flow control: when it is low, every stage holds, and the caller must keep the inputs meaningful only on enabled edges. There is no ready signal and no back-pressure. A synchronous clear empties the whole pipeline and the total. It wins over the enable.

Top module: `preadd_mac`

## Requirements
- R1: After each enabled, non-clearing rising edge, `acc_out` equals its previous value plus the sign-extended product `(a_in + d_in) * b_in` of an earlier operand set. All values are two's-complement signed.
- R2: An operand set sampled on enabled edge k enters `acc_out` on the third enabled edge after k. The capture register, the sum register, the product register and the accumulator make up four register stages in total.
- R3: The pre-adder sum is computed one bit wider than `a_in`/`d_in`. With both inputs at -2^26 and `b_in` = 1, the result is -2^27 and not a wrapped value.
- R4: The accumulator wraps modulo 2^48 without saturation. Repeatedly adding large positive products eventually makes `acc_out` negative.
- R5: When `clr` is high at a rising edge, every pipeline register and `acc_out` are zero after that edge.
- R6: `clr` takes priority over `clk_en`. A clear with `clk_en` low still zeroes `acc_out`.
- R7: While `clk_en` is low and `clr` is low, every stage holds its value: `acc_out` does not change, and the operands already in flight are not lost or altered by the inputs applied during the stall.
- R8: After a clear, `acc_out` reads zero on the clearing edge and on the next three enabled edges, whatever operands are applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clk_en | input | 1 | Clock enable for all stages; low holds every register |
| clr | input | 1 | Synchronous clear of all stages; overrides `clk_en` |
| a_in | input | 27 | Signed pre-adder operand |
| d_in | input | 27 | Signed pre-adder operand |
| b_in | input | 18 | Signed multiplier operand |
| acc_out | output | 48 | Signed accumulated result |

## Verification
Every internal register feeds the running total, so a corrupted stage never stays hidden. A bad sum, product or capture value shows up in `acc_out` within at most three enabled edges, and from then on it shifts every later total by a constant. A stage that ignores the enable shows up as a total that differs from the reference after the stall ends. A stage that ignores the clear shows up as a non-zero `acc_out` inside the four-edge quiet window that follows a clear.

// File: rtl/preadd_mac_pkg.sv
package preadd_mac_pkg;
  // Default geometry of the datapath
  localparam int unsigned DEF_OPW   = 27;  // pre-adder operand width
  localparam int unsigned DEF_MULW  = 18;  // multiplier operand width
  localparam int unsigned DEF_ACCW  = 48;  // accumulator width
  localparam int unsigned DEF_DEPTH = 4;   // register stages input -> total
  // Fixed stages: capture, sum, accumulator; the rest are product stages
  localparam int unsigned FIXED_STAGES = 3;
endpackage

// File: rtl/preadd_mac_capture.sv
module preadd_mac_capture #(
  parameter int unsigned OPW  = preadd_mac_pkg::DEF_OPW,
  parameter int unsigned MULW = preadd_mac_pkg::DEF_MULW
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic                   clr,
  input  logic signed [OPW-1:0]  a_i,
  input  logic signed [OPW-1:0]  d_i,
  input  logic signed [MULW-1:0] b_i,
  output logic signed [OPW-1:0]  a_q,
  output logic signed [OPW-1:0]  d_q,
  output logic signed [MULW-1:0] b_q
);
  always_ff @(posedge clk) begin
    if (clr) begin
      a_q <= '0;
      d_q <= '0;
      b_q <= '0;
    end else if (en) begin
      a_q <= a_i;
      d_q <= d_i;
      b_q <= b_i;
    end
  end
endmodule

// File: rtl/preadd_mac_mult.sv
module preadd_mac_mult #(
  parameter int unsigned OPW    = preadd_mac_pkg::DEF_OPW,
  parameter int unsigned MULW   = preadd_mac_pkg::DEF_MULW,
  parameter int unsigned PSTAGE = 1,
  localparam int unsigned SW    = OPW + 1,
  localparam int unsigned MW    = SW + MULW
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic                   clr,
  input  logic signed [OPW-1:0]  a_q,
  input  logic signed [OPW-1:0]  d_q,
  input  logic signed [MULW-1:0] b_q,
  output logic signed [MW-1:0]   prod_q
);
  logic signed [SW-1:0]   sum_q;
  logic signed [MULW-1:0] b_d;
  logic signed [SW-1:0]   sum_c;
  logic signed [MW-1:0]   prod_c;

  // Widened pre-adder: cannot overflow
  assign sum_c  = SW'(a_q) + SW'(d_q);
  assign prod_c = MW'(sum_q) * MW'(b_d);

  always_ff @(posedge clk) begin
    if (clr) begin
      sum_q <= '0;
      b_d   <= '0;
    end else if (en) begin
      sum_q <= sum_c;
      b_d   <= b_q;
    end
  end

  // Product register chain; depth set by the pipeline parameter
  logic signed [MW-1:0] pchain [PSTAGE];

  genvar gi;
  generate
    for (gi = 0; gi < PSTAGE; gi++) begin : g_pstage
      always_ff @(posedge clk) begin
        if (clr) begin
          pchain[gi] <= '0;
        end else if (en) begin
          if (gi == 0) pchain[gi] <= prod_c;
          else         pchain[gi] <= pchain[(gi == 0) ? 0 : gi-1];
        end
      end
    end
  endgenerate

  assign prod_q = pchain[PSTAGE-1];
endmodule

// File: rtl/preadd_mac_accum.sv
module preadd_mac_accum #(
  parameter int unsigned MW   = 46,
  parameter int unsigned ACCW = preadd_mac_pkg::DEF_ACCW
) (
  input  logic                   clk,
  input  logic                   en,
  input  logic                   clr,
  input  logic signed [MW-1:0]   prod_q,
  output logic signed [ACCW-1:0] acc_q
);
  logic signed [ACCW-1:0] prod_x;

  // Sign extension to total width; sum wraps modulo 2^ACCW
  assign prod_x = ACCW'(prod_q);

  always_ff @(posedge clk) begin
    if (clr)     acc_q <= '0;
    else if (en) acc_q <= acc_q + prod_x;
  end
endmodule

// File: rtl/preadd_mac.sv
module preadd_mac #(
  parameter int unsigned OPW   = preadd_mac_pkg::DEF_OPW,
  parameter int unsigned MULW  = preadd_mac_pkg::DEF_MULW,
  parameter int unsigned ACCW  = preadd_mac_pkg::DEF_ACCW,
  parameter int unsigned DEPTH = preadd_mac_pkg::DEF_DEPTH
) (
  input  logic                   clk,
  input  logic                   clk_en,
  input  logic                   clr,
  input  logic signed [OPW-1:0]  a_in,
  input  logic signed [OPW-1:0]  d_in,
  input  logic signed [MULW-1:0] b_in,
  output logic signed [ACCW-1:0] acc_out
);
  // DEPTH must be at least 4; ACCW must cover the product width
  localparam int unsigned MW     = OPW + 1 + MULW;
  localparam int unsigned PSTAGE = DEPTH - preadd_mac_pkg::FIXED_STAGES;

  logic signed [OPW-1:0]  a_q, d_q;
  logic signed [MULW-1:0] b_q;
  logic signed [MW-1:0]   prod_q;

  preadd_mac_capture #(.OPW(OPW), .MULW(MULW)) u_cap (
    .clk(clk), .en(clk_en), .clr(clr),
    .a_i(a_in), .d_i(d_in), .b_i(b_in),
    .a_q(a_q), .d_q(d_q), .b_q(b_q)
  );

  preadd_mac_mult #(.OPW(OPW), .MULW(MULW), .PSTAGE(PSTAGE)) u_mul (
    .clk(clk), .en(clk_en), .clr(clr),
    .a_q(a_q), .d_q(d_q), .b_q(b_q),
    .prod_q(prod_q)
  );

  preadd_mac_accum #(.MW(MW), .ACCW(ACCW)) u_acc (
    .clk(clk), .en(clk_en), .clr(clr),
    .prod_q(prod_q), .acc_q(acc_out)
  );
endmodule

// File: rtl/preadd_mac_chk.sv
module preadd_mac_chk #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned ACCW  = 48,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            clk_en,
  input logic            clr,
  input logic [ACCW-1:0] acc_out
);
  // Becomes 1 after the first clear; before that the state is undefined
  logic armed = 1'b0;
  logic [CW-1:0] quiet_cnt;

  always_ff @(posedge clk) begin
    if (clr) armed <= 1'b1;
  end

  // Enabled edges since the last clear, saturating at DEPTH
  always_ff @(posedge clk) begin
    if (clr)                                 quiet_cnt <= '0;
    else if (clk_en && quiet_cnt != CW'(DEPTH)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!armed)
    clr |=> (acc_out == '0));

  assert_clear_over_en_R6: assert property (@(posedge clk) disable iff (!armed)
    (clr && !clk_en) |=> (acc_out == '0));

  assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!armed)
    (!clr && !clk_en) |=> $stable(acc_out));

  assert_quiet_window_R8: assert property (@(posedge clk) disable iff (!armed)
    (quiet_cnt < CW'(DEPTH)) |-> (acc_out == '0));

  assert_known_R1: assert property (@(posedge clk) disable iff (!armed)
    !$isunknown(acc_out));
endmodule

bind preadd_mac preadd_mac_chk #(.DEPTH(DEPTH), .ACCW(ACCW)) u_chk (
  .clk(clk), .clk_en(clk_en), .clr(clr), .acc_out(acc_out)
);

// File: tb/sim_preadd_mac.sv
`timescale 1ns/1ps
module sim_preadd_mac;
  localparam int PERIOD = 10;
  localparam int LAT    = 4;

  logic clk = 1'b0;
  logic clk_en = 1'b0;
  logic clr = 1'b1;
  logic signed [26:0] a_in = '0;
  logic signed [26:0] d_in = '0;
  logic signed [17:0] b_in = '0;
  logic signed [47:0] acc_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference: products delayed by LAT-1 enabled edges, then summed
  logic signed [47:0] m_acc = '0;
  logic signed [47:0] m_pipe [LAT-1];

  always #(PERIOD/2) clk = ~clk;

  preadd_mac u0 (
    .clk(clk), .clk_en(clk_en), .clr(clr),
    .a_in(a_in), .d_in(d_in), .b_in(b_in), .acc_out(acc_out)
  );

  function automatic logic signed [47:0] ref_prod(input logic signed [26:0] a,
                                                  input logic signed [26:0] d,
                                                  input logic signed [17:0] b);
    longint s;
    s = (longint'(a) + longint'(d)) * longint'(b);
    return 48'(s);
  endfunction

  task automatic check(input string req, input logic signed [47:0] act,
                       input logic signed [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: acc_out=%0d expected %0d", req, act, exp);
    end
  endtask

  // Apply inputs, take one edge, advance the model, sample after the edge
  task automatic step(input bit en, input bit cl, input logic signed [26:0] a,
                      input logic signed [26:0] d, input logic signed [17:0] b);
    clk_en = en; clr = cl; a_in = a; d_in = d; b_in = b;
    @(posedge clk);
    if (cl) begin
      m_acc = '0;
      for (int i = 0; i < LAT-1; i++) m_pipe[i] = '0;
    end else if (en) begin
      m_acc = m_acc + m_pipe[LAT-2];
      for (int i = LAT-2; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = ref_prod(a, d, b);
    end
    #1;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic signed [47:0] held;
    bit went_neg;
    void'($urandom(32'd2024));
    for (int i = 0; i < LAT-1; i++) m_pipe[i] = '0;

    // R5: clear from power-up
    step(1'b0, 1'b1, 27'sd0, 27'sd0, 18'sd0);
    step(1'b0, 1'b1, 27'sd0, 27'sd0, 18'sd0);
    check("R5 clear at start", acc_out, 48'sd0);

    // R8 and R2: single operand set, then zeros
    step(1'b1, 1'b0, 27'sd5, -27'sd2, 18'sd7);
    check("R8 quiet edge 1", acc_out, 48'sd0);
    step(1'b1, 1'b0, 27'sd0, 27'sd0, 18'sd0);
    check("R8 quiet edge 2", acc_out, 48'sd0);
    step(1'b1, 1'b0, 27'sd0, 27'sd0, 18'sd0);
    check("R8 quiet edge 3", acc_out, 48'sd0);
    step(1'b1, 1'b0, 27'sd0, 27'sd0, 18'sd0);
    check("R2 latency product arrives", acc_out, 48'sd21);

    // R8 with busy inputs after clear
    step(1'b1, 1'b1, 27'sd0, 27'sd0, 18'sd0);
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 1'b0, 27'sd1000, 27'sd77, -18'sd300);
      check("R8 quiet with operands", acc_out, 48'sd0);
    end

    // R3: pre-adder at the negative limit
    step(1'b1, 1'b1, 27'sd0, 27'sd0, 18'sd0);
    step(1'b1, 1'b0, -27'sd67108864, -27'sd67108864, 18'sd1);
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 27'sd0, 27'sd0, 18'sd0);
    check("R3 wide pre-add", acc_out, -48'sd134217728);

    // R1: constrained random, with occasional stalls and clears
    for (int k = 0; k < 400; k++) begin
      automatic bit en = ($urandom_range(0, 99) < 85);
      automatic bit cl = ($urandom_range(0, 99) < 2);
      step(en, cl, 27'($urandom), 27'($urandom), 18'($urandom));
      check("R1 random accumulate", acc_out, m_acc);
    end

    // R7: stall with changing inputs, then resume
    step(1'b1, 1'b0, 27'sd12345, -27'sd345, 18'sd99);
    step(1'b1, 1'b0, -27'sd4000, 27'sd1, -18'sd17);
    held = acc_out;
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0, 27'($urandom), 27'($urandom), 18'($urandom));
      check("R7 hold during stall", acc_out, held);
    end
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, 27'sd0, 27'sd0, 18'sd0);
      check("R7 in-flight data kept", acc_out, m_acc);
    end

    // R6: clear while enable is low
    step(1'b0, 1'b1, 27'sd9, 27'sd9, 18'sd9);
    check("R6 clear over enable", acc_out, 48'sd0);
    step(1'b0, 1'b0, 27'sd9, 27'sd9, 18'sd9);
    check("R6 stays cleared", acc_out, 48'sd0);

    // R4: wrap of the total with large positive products
    step(1'b1, 1'b1, 27'sd0, 27'sd0, 18'sd0);
    went_neg = 1'b0;
    for (int k = 0; k < 24; k++) begin
      step(1'b1, 1'b0, 27'sd67108863, 27'sd67108863, 18'sd131071);
      check("R4 wrapping total", acc_out, m_acc);
      if (acc_out < 0) went_neg = 1'b1;
    end
    n_tests++;
    if (!went_neg) begin
      n_fail++;
      $display("FAIL R4: acc_out never wrapped negative, expected a sign flip");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule